// File: doc/BRIEF.md
# Statistics Counter Extension Bank

This block holds the upper halves of a bank of wide statistics counters whose lower 48 bits live in a hardware counter engine. The engine steps one counter address per clock cycle through the whole bank. Each time the 48-bit counter at the presented address wraps, it raises an increment pulse. The bank keeps a 16-bit extension word for every address and adds one to it on each pulse. Software can then combine the two halves into counters wider than 48 bits.

The address space is split evenly among four ports, and the top two address bits name the port. A per-port enable decides whether that port's extension words count at all. A per-port tick flag arrives on the same cycle as some address of the rotation. From that point the bank copies each of the port's extension values, as it stands after that cycle's increment, into a snapshot store. Once all of the port's addresses have been copied, it raises that port's ready flag. A registered read port returns either the live value or the snapshot value of any address.

Top module: `stat_ext_bank`

## Requirements
- R1: When `cnt_inc` is 1 in a cycle and the port of `cnt_addr` is enabled, the live extension word at `cnt_addr` grows by exactly one. Every address holds its own word, and all words are zero after reset.
- R2: Pulses to the same address on consecutive cycles are all counted, with none lost to the memory's read-modify-write latency.
- R3: Each extension word is 16 bits and wraps silently. After 65536 increments from zero it reads 0, and after one more it reads 1.
- R4: The port of an address is `cnt_addr[8:7]`. When `mode_en[p]` is 0, increments to port p's addresses leave their words unchanged, and words of other ports still count.
- R5: When `tick_flags[p]` is 1 in a cycle, capture for port p starts with the address presented in that same cycle. Each presentation of one of port p's addresses then copies that word's value, including the increment of that cycle, into the snapshot entry of that address. Capture ends after 128 such copies, and the rotation may wrap from 511 to 0 while it runs.
- R6: `ready[p]` becomes 1 two clock edges after the cycle that presented port p's 128th captured address, and not before.
- R7: `tick_flags[p]` clears `ready[p]` at the next edge and wins over a completion at the same edge. The ready flags of other ports are unaffected.
- R8: Once capture for an address has ended, later increments change only the live word. The snapshot entry keeps its captured value.
- R9: `rd_data` is registered. It shows the word at `rd_addr` one edge after the request, live when `rd_live` is 1 and snapshot when it is 0. An increment's write lands one edge after its pulse cycle, so a read requested in the very next cycle still returns the old value.
- R10: Reset is synchronous and active-high. It clears all live words, all snapshot entries, every ready flag and all capture state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_en | input | 4 | Per-port enable of extension counting |
| cnt_addr | input | 9 | Counter address presented by the rotation this cycle |
| cnt_inc | input | 1 | 48-bit counter at `cnt_addr` wrapped this cycle |
| tick_flags | input | 4 | Per-port tick marker at this point of the rotation |
| rd_addr | input | 9 | Read port address |
| rd_live | input | 1 | 1 reads the live word, 0 reads the snapshot |
| rd_data | output | 16 | Registered read data |
| ready | output | 4 | Per-port snapshot complete flag |

## Verification
Single pulses and back-to-back pulse trains to one address are used, and so are pulses spaced by idle cycles. They separate a working write bypass from one that drops the second of two adjacent increments. A 65537-pulse run shows that the word wraps rather than saturates. Two rotations are run with ticks at different points: one at the start of a port's range and one in the middle of a range, so that capture must cross the 511-to-0 wrap. Together they tell apart end detection by address from counting of visits, and they pin down the edge on which ready rises. Disabled-port pulses, increments after capture and a read issued right after a pulse show that snapshot and live words are kept apart and that the write lands one edge late.

// File: rtl/stat_ext_pkg.sv
package stat_ext_pkg;
  localparam int DEF_ADDR_W = 9;
  localparam int DEF_PORTS  = 4;
  localparam int DEF_EXT_W  = 16;

  typedef enum logic {
    SRC_SNAP = 1'b0,
    SRC_LIVE = 1'b1
  } rd_src_e;
endpackage

// File: rtl/ext_ctr_mem.sv
module ext_ctr_mem #(
  parameter int ADDR_W = 9,
  parameter int EXT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_a,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_a,
  input  logic [EXT_W-1:0]  wr_d,
  output logic [EXT_W-1:0]  rd_q,
  output logic              fwd_hit,
  input  logic [ADDR_W-1:0] rd2_a,
  output logic [EXT_W-1:0]  rd2_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [EXT_W-1:0] mem [DEPTH];

  // a write landing at the same edge as a read of that address is forwarded
  assign fwd_hit = wr_en && (wr_a == rd_a);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_q  <= '0;
      rd2_q <= '0;
    end else begin
      if (wr_en) mem[wr_a] <= wr_d;
      rd_q  <= fwd_hit ? wr_d : mem[rd_a];
      rd2_q <= mem[rd2_a];
    end
  end
endmodule

// File: rtl/ext_snap_mem.sv
module ext_snap_mem #(
  parameter int ADDR_W = 9,
  parameter int EXT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [EXT_W-1:0]  wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [EXT_W-1:0]  rq
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [EXT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rq <= '0;
    end else begin
      if (we) mem[wa] <= wd;
      rq <= mem[ra];
    end
  end
endmodule

// File: rtl/ext_port_track.sv
module ext_port_track #(
  parameter int PER_PORT = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hit,
  output logic cap,
  output logic done_q,
  output logic ready
);
  localparam int CNT_W = $clog2(PER_PORT + 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] nxt;
  logic             last;

  always_comb begin
    base = tick ? '0 : cnt;
    nxt  = base + CNT_W'(1);
    cap  = hit && (armed || tick);
    last = cap && (nxt == CNT_W'(PER_PORT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      cnt    <= '0;
      done_q <= 1'b0;
      ready  <= 1'b0;
    end else begin
      done_q <= last;
      if (cap) begin
        armed <= !last;
        cnt   <= last ? '0 : nxt;
      end else if (tick) begin
        armed <= 1'b1;
        cnt   <= '0;
      end
      // R7: a tick wins over a completion arriving at the same edge
      if (tick)        ready <= 1'b0;
      else if (done_q) ready <= 1'b1;
    end
  end
endmodule

// File: rtl/stat_ext_bank.sv
module stat_ext_bank
  import stat_ext_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int PORTS  = DEF_PORTS,
  parameter int EXT_W  = DEF_EXT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORTS-1:0]  mode_en,
  input  logic [ADDR_W-1:0] cnt_addr,
  input  logic              cnt_inc,
  input  logic [PORTS-1:0]  tick_flags,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_live,
  output logic [EXT_W-1:0]  rd_data,
  output logic [PORTS-1:0]  ready
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PORT_W   = $clog2(PORTS);
  localparam int PER_PORT = DEPTH / PORTS;

  function automatic logic [EXT_W-1:0] ext_next(input logic [EXT_W-1:0] v,
                                                input logic bump);
    return v + {{(EXT_W-1){1'b0}}, bump};
  endfunction

  // stage 0: presented address
  logic [PORT_W-1:0] port_sel;
  logic              en_s0;
  logic [PORTS-1:0]  hit_vec;
  logic [PORTS-1:0]  cap_vec;
  logic [PORTS-1:0]  done_vec;

  assign port_sel = cnt_addr[ADDR_W-1 -: PORT_W];
  assign en_s0    = mode_en[port_sel];

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    assign hit_vec[p] = (port_sel == PORT_W'(p));
    ext_port_track #(.PER_PORT(PER_PORT)) u_track (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick_flags[p]),
      .hit    (hit_vec[p]),
      .cap    (cap_vec[p]),
      .done_q (done_vec[p]),
      .ready  (ready[p])
    );
  end

  // stage 1: read-modify-write
  logic [ADDR_W-1:0] s1_addr;
  logic              s1_bump;
  logic              s1_cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_addr <= '0;
      s1_bump <= 1'b0;
      s1_cap  <= 1'b0;
    end else begin
      s1_addr <= cnt_addr;
      s1_bump <= cnt_inc && en_s0;
      s1_cap  <= |cap_vec;
    end
  end

  // named internal events
  logic [EXT_W-1:0]  rd_cur;
  logic              wb_we;
  logic [ADDR_W-1:0] wb_addr;
  logic [EXT_W-1:0]  wb_data;
  logic              snap_we;
  logic              fwd_hit;
  logic [EXT_W-1:0]  live_q;
  logic [EXT_W-1:0]  snap_q;

  assign wb_we   = s1_bump;
  assign wb_addr = s1_addr;
  assign wb_data = ext_next(rd_cur, s1_bump);
  assign snap_we = s1_cap;

  ext_ctr_mem #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_live (
    .clk     (clk),
    .rst     (rst),
    .rd_a    (cnt_addr),
    .wr_en   (wb_we),
    .wr_a    (wb_addr),
    .wr_d    (wb_data),
    .rd_q    (rd_cur),
    .fwd_hit (fwd_hit),
    .rd2_a   (rd_addr),
    .rd2_q   (live_q)
  );

  ext_snap_mem #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_snap (
    .clk (clk),
    .rst (rst),
    .we  (snap_we),
    .wa  (wb_addr),
    .wd  (wb_data),
    .ra  (rd_addr),
    .rq  (snap_q)
  );

  // read source follows the data by one edge
  rd_src_e rd_src_q;

  always_ff @(posedge clk) begin
    if (rst) rd_src_q <= SRC_SNAP;
    else     rd_src_q <= rd_live ? SRC_LIVE : SRC_SNAP;
  end

  assign rd_data = (rd_src_q == SRC_LIVE) ? live_q : snap_q;
endmodule

// File: rtl/stat_ext_bank_chk.sv
module stat_ext_bank_chk #(
  parameter int ADDR_W = 9,
  parameter int PORTS  = 4,
  parameter int EXT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [PORTS-1:0]  mode_en,
  input logic [ADDR_W-1:0] cnt_addr,
  input logic              cnt_inc,
  input logic [PORTS-1:0]  tick_flags,
  input logic [PORTS-1:0]  ready,
  input logic              wb_we,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [EXT_W-1:0]  wb_data,
  input logic [PORTS-1:0]  done_vec
);
  localparam int PORT_W = $clog2(PORTS);

  logic [PORT_W-1:0] chk_port;
  assign chk_port = cnt_addr[ADDR_W-1 -: PORT_W];

  assert_inc_write_R1: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && mode_en[chk_port]) |=> (wb_we && wb_addr == $past(cnt_addr)));

  assert_b2b_chain_R2: assert property (@(posedge clk) disable iff (rst)
    (wb_we && $past(wb_we) && wb_addr == $past(wb_addr))
      |-> (wb_data == EXT_W'($past(wb_data) + 1'b1)));

  assert_disabled_port_R4: assert property (@(posedge clk) disable iff (rst)
    (cnt_inc && !mode_en[chk_port]) |=> !wb_we);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (ready == '0));

  for (genvar p = 0; p < PORTS; p++) begin : g_chk
    assert_ready_rise_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(ready[p]) |-> $past(done_vec[p]));

    assert_tick_clear_R7: assert property (@(posedge clk) disable iff (rst)
      tick_flags[p] |=> !ready[p]);
  end
endmodule

bind stat_ext_bank stat_ext_bank_chk #(
  .ADDR_W(ADDR_W), .PORTS(PORTS), .EXT_W(EXT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_en    (mode_en),
  .cnt_addr   (cnt_addr),
  .cnt_inc    (cnt_inc),
  .tick_flags (tick_flags),
  .ready      (ready),
  .wb_we      (wb_we),
  .wb_addr    (wb_addr),
  .wb_data    (wb_data),
  .done_vec   (done_vec)
);

// File: tb/stat_ext_bank_bench.sv
`timescale 1ns/1ps
module stat_ext_bank_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  mode_en;
  logic [8:0]  cnt_addr;
  logic        cnt_inc;
  logic [3:0]  tick_flags;
  logic [8:0]  rd_addr;
  logic        rd_live;
  logic [15:0] rd_data;
  logic [3:0]  ready;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  stat_ext_bank u_stat_ext_bank (
    .clk        (clk),
    .rst        (rst),
    .mode_en    (mode_en),
    .cnt_addr   (cnt_addr),
    .cnt_inc    (cnt_inc),
    .tick_flags (tick_flags),
    .rd_addr    (rd_addr),
    .rd_live    (rd_live),
    .rd_data    (rd_data),
    .ready      (ready)
  );

  typedef struct packed {
    logic [8:0]  addr;
    logic [7:0]  pulses;
    logic        spaced;
    logic [15:0] expect_v;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{9'd5,   8'd1, 1'b0, 16'd1},
    '{9'd5,   8'd3, 1'b0, 16'd4},
    '{9'd200, 8'd2, 1'b1, 16'd2},
    '{9'd300, 8'd5, 1'b0, 16'd5},
    '{9'd511, 8'd2, 1'b1, 16'd2},
    '{9'd5,   8'd2, 1'b1, 16'd6}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge; one rising edge in between
  task automatic cyc(input logic [8:0] a, input logic inc, input logic [3:0] tk);
    cnt_addr   = a;
    cnt_inc    = inc;
    tick_flags = tk;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [8:0] a, input bit live, input int exp, input string tag);
    cyc(9'd0, 1'b0, 4'd0);
    rd_addr = a;
    rd_live = live;
    cyc(9'd0, 1'b0, 4'd0);
    chk(rd_data == 16'(exp), tag, rd_data, exp);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; mode_en = 4'b1111; cnt_addr = '0; cnt_inc = 1'b0;
    tick_flags = '0; rd_addr = '0; rd_live = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(ready == 4'd0, "R10 ready after reset", ready, 0);
    rd_chk(9'd5, 1'b1, 0, "R1 live word zero after reset");

    // R1 R2: vector table, back-to-back and spaced pulses
    for (int v = 0; v < 6; v++) begin
      for (int n = 0; n < int'(VECS[v].pulses); n++) begin
        cyc(VECS[v].addr, 1'b1, 4'd0);
        if (VECS[v].spaced) cyc(9'd0, 1'b0, 4'd0);
      end
      rd_chk(VECS[v].addr, 1'b1, int'(VECS[v].expect_v),
             VECS[v].spaced ? "R1 spaced pulses" : "R2 back-to-back pulses");
    end

    // R3: wrap after 65536 increments
    for (int n = 0; n < 65536; n++) cyc(9'd10, 1'b1, 4'd0);
    rd_chk(9'd10, 1'b1, 0, "R3 wrap to zero");
    cyc(9'd10, 1'b1, 4'd0);
    rd_chk(9'd10, 1'b1, 1, "R3 one after wrap");

    // R4: port 1 (addr[8:7]=01) disabled
    mode_en = 4'b1101;
    for (int n = 0; n < 3; n++) cyc(9'd130, 1'b1, 4'd0);
    cyc(9'd5, 1'b1, 4'd0);
    rd_chk(9'd130, 1'b1, 0, "R4 disabled port ignores pulses");
    rd_chk(9'd5, 1'b1, 7, "R4 enabled port still counts");
    mode_en = 4'b1111;

    // R9: read right after a pulse sees the old value
    cyc(9'd20, 1'b1, 4'd0);
    rd_addr = 9'd20; rd_live = 1'b1;
    cyc(9'd0, 1'b0, 4'd0);
    chk(rd_data == 16'd0, "R9 write lands one edge late", rd_data, 0);
    cyc(9'd0, 1'b0, 4'd0);
    chk(rd_data == 16'd1, "R9 registered read after write", rd_data, 1);

    // R5 R6: port 2 (256..383) tick at start of rotation
    cyc(9'd0, 1'b0, 4'b0100);
    chk(ready[2] == 1'b0, "R7 ready low after tick", ready[2], 0);
    for (int a = 1; a < 512; a++) begin
      cyc(9'(a), a == 260, 4'd0);
      if (a == 383) chk(ready[2] == 1'b0, "R6 ready not early", ready[2], 0);
      if (a == 384) chk(ready[2] == 1'b1, "R6 ready two edges after last", ready[2], 1);
    end
    cyc(9'd260, 1'b1, 4'd0);
    cyc(9'd260, 1'b1, 4'd0);
    rd_chk(9'd260, 1'b0, 1, "R8 snapshot holds captured value");
    rd_chk(9'd260, 1'b1, 3, "R1 live keeps counting after capture");
    rd_chk(9'd300, 1'b0, 5, "R5 snapshot of earlier count");
    rd_chk(9'd256, 1'b0, 0, "R5 snapshot of untouched word");

    // R5 R6: port 3 (384..511) tick mid-range, capture crosses 511->0
    cyc(9'd400, 1'b0, 4'b1000);
    for (int j = 1; j < 512; j++) begin
      cyc(9'((400 + j) % 512), 1'b0, 4'd0);
      if (((400 + j) % 512) == 399)
        chk(ready[3] == 1'b0, "R6 mid-range not early", ready[3], 0);
    end
    cyc(9'd400, 1'b0, 4'd0);
    chk(ready[3] == 1'b1, "R6 mid-range ready after wrap", ready[3], 1);
    rd_chk(9'd511, 1'b0, 2, "R5 mid-range snapshot value");

    // R7: tick clears only its own port
    cyc(9'd0, 1'b0, 4'b0100);
    chk(ready[2] == 1'b0, "R7 tick clears ready", ready[2], 0);
    chk(ready[3] == 1'b1, "R7 other port unaffected", ready[3], 1);

    // R10: reset clears everything
    rst = 1'b1;
    cyc(9'd0, 1'b0, 4'd0);
    cyc(9'd0, 1'b0, 4'd0);
    rst = 1'b0;
    chk(ready == 4'd0, "R10 ready cleared by reset", ready, 0);
    rd_chk(9'd5, 1'b1, 0, "R10 live cleared by reset");
    rd_chk(9'd300, 1'b0, 0, "R10 snapshot cleared by reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule